// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds the eight 80-bit data registers of a floating-point unit, arranged as a rotating stack. Every operand reference is a logical depth `i` below the top of stack. The physical slot is `(top + i) mod 8`, where `top` is a 3-bit pointer that the block keeps. The block treats register contents as opaque words. The execution unit supplies values to push or write and consumes the values it reads or pops. The block does no arithmetic or format conversion.

Each slot carries a tag that marks it valid or empty. The block checks every operation against these tags before it commits anything. A push onto a slot that is already valid is an overflow. A pop, read or exchange that touches an empty slot is an underflow. When either fault occurs, the block raises a stack-fault flag and an invalid-operation flag, and it drives a direction bit for the status word. The current top pointer is also brought out, so that the status word can place it in bits 13:11. Fault flags are combinational for the operation presented in the current cycle. The state update happens at the next clock edge.

Top module: `fp_regstack`

## Requirements
- R1: After the asynchronous reset, or after a cycle with `init_i` high, the top pointer is 0 and all eight slots are empty. A cycle with `init_i` high ignores the operation presented with it and raises no fault flag.
- R2: PUSH (`op_i`=1) decrements the top pointer modulo 8 and stores `wdata_i` as the new ST0, which marks that slot valid. The value that was ST0 before the push then reads as ST1.
- R3: READ (`op_i`=3) returns on `rdata_o`, in the same cycle, the slot at physical index `(top_o + idx_i) mod 8`.
- R4: POP (`op_i`=2) returns ST0 on `rdata_o` in the same cycle. At the next edge the block marks that slot empty and increments the top pointer modulo 8.
- R5: A PUSH whose target slot `(top_o - 1) mod 8` is valid is an overflow. The block raises `stk_fault_o` and `invalid_o`, and drives `c1_o` to 1.
- R6: A POP of an empty ST0, or a READ of an empty ST(i), is an underflow. The block raises `stk_fault_o` and `invalid_o`, and drives `c1_o` to 0.
- R7: A faulting operation leaves the top pointer, all tags and all slot contents unchanged.
- R8: WRITE (`op_i`=4) stores `wdata_i` into ST(`idx_i`) and marks that slot valid, whether it was empty or valid before. It never faults.
- R9: XCHG (`op_i`=5) swaps ST0 and ST(`idx_i`) in one cycle. If either slot is empty, the exchange is an underflow with the flags of R6.
- R10: NOP (`op_i`=0) and the unused codes 6 and 7 change no state and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous initialise: top to 0, all slots empty |
| op_i | input | 3 | Operation: 0 NOP, 1 PUSH, 2 POP, 3 READ, 4 WRITE, 5 XCHG |
| idx_i | input | 3 | Logical depth i for READ, WRITE, XCHG |
| wdata_i | input | 80 | Value for PUSH and WRITE |
| rdata_o | output | 80 | ST0 during POP and XCHG, otherwise ST(idx_i) |
| top_o | output | 3 | Current top-of-stack pointer |
| stk_fault_o | output | 1 | Stack overflow or underflow on the current operation |
| c1_o | output | 1 | Fault direction: 1 overflow, 0 underflow |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The inline assertions check pointer bookkeeping on every cycle. They cover the decrement after an accepted push, the increment and tag clear after an accepted pop, the freeze of pointer and tags after any fault, the clean state after initialise, and the agreement of the direction bit with the operation that faulted. Only the bench scenarios can show that data moves correctly: the stack order after pushes, the wrap of the physical index, an exchange that really swaps the two values, and the fact that a rejected push leaves the old contents readable.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int unsigned STK_DEPTH = 8;
  localparam int unsigned STK_WIDTH = 80;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_XCHG  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fpst_ptr.sv
module fpst_ptr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             dec_i,
  input  logic             inc_i,
  input  logic [PTR_W-1:0] idx_i,
  output logic [PTR_W-1:0] top_o,
  output logic [PTR_W-1:0] top_dec_o,
  output logic [PTR_W-1:0] phys_o
);
  logic [PTR_W-1:0] top_q, top_d;
  logic             top_en;

  // depth is a power of two, so truncation gives the modulo wrap
  assign top_dec_o = top_q - PTR_W'(1);
  assign phys_o    = top_q + idx_i;
  assign top_o     = top_q;
  assign top_en    = init_i | dec_i | inc_i;

  always_comb begin
    top_d = top_q;
    if (init_i)     top_d = '0;
    else if (dec_i) top_d = top_dec_o;
    else if (inc_i) top_d = top_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_d;
  end
endmodule

// File: rtl/fpst_tags.sv
module fpst_tags #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             set_en_i,
  input  logic [PTR_W-1:0] set_idx_i,
  input  logic             clr_en_i,
  input  logic [PTR_W-1:0] clr_idx_i,
  output logic [DEPTH-1:0] valid_o
);
  logic [DEPTH-1:0] valid_q, valid_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_comb begin
      valid_d[g] = valid_q[g];
      if (init_i)                                       valid_d[g] = 1'b0;
      else if (set_en_i && set_idx_i == PTR_W'(g))      valid_d[g] = 1'b1;
      else if (clr_en_i && clr_idx_i == PTR_W'(g))      valid_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign valid_o = valid_q;

  // one operation per cycle never both fills and frees a slot
  p_set_clr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en_i && clr_en_i));
endmodule

// File: rtl/fpst_regfile.sv
module fpst_regfile #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 80,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wa_en_i,
  input  logic [PTR_W-1:0] wa_addr_i,
  input  logic [WIDTH-1:0] wa_data_i,
  input  logic             wb_en_i,
  input  logic [PTR_W-1:0] wb_addr_i,
  input  logic [WIDTH-1:0] wb_data_i,
  input  logic [PTR_W-1:0] ra_addr_i,
  output logic [WIDTH-1:0] ra_data_o,
  input  logic [PTR_W-1:0] rb_addr_i,
  output logic [WIDTH-1:0] rb_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             hit_a, hit_b, slot_en;
    logic [WIDTH-1:0] slot_d;

    assign hit_a   = wa_en_i && wa_addr_i == PTR_W'(g);
    assign hit_b   = wb_en_i && wb_addr_i == PTR_W'(g);
    assign slot_en = hit_a | hit_b;
    assign slot_d  = hit_a ? wa_data_i : wb_data_i;

    // data slots carry no reset; the tags say whether they hold anything
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= slot_d;
    end
  end

  assign ra_data_o = slot_q[ra_addr_i];
  assign rb_data_o = slot_q[rb_addr_i];
endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
  import fpst_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [2:0]       op_i,
  input  logic [PTR_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [PTR_W-1:0] top_o,
  output logic             stk_fault_o,
  output logic             c1_o,
  output logic             invalid_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] top, top_dec, phys;
  logic [DEPTH-1:0] valid;
  logic [WIDTH-1:0] rd_top, rd_phys;
  logic             ovf, unf, fault, go;
  logic             do_push, do_pop, do_write, do_xchg;
  logic             wa_en;
  logic [PTR_W-1:0] wa_addr, ra_addr;
  logic [WIDTH-1:0] wa_data;

  assign op = stk_op_e'(op_i);

  // ---- fault detection against the tags of the current state
  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (!init_i) begin
      unique case (op)
        OP_PUSH: ovf = valid[top_dec];
        OP_POP:  unf = !valid[top];
        OP_READ: unf = !valid[phys];
        OP_XCHG: unf = !valid[top] || !valid[phys];
        default: ;
      endcase
    end
  end

  assign fault       = ovf | unf;
  assign go          = !init_i && !fault;
  assign stk_fault_o = fault;
  assign invalid_o   = fault;
  assign c1_o        = ovf;

  assign do_push  = go && op == OP_PUSH;
  assign do_pop   = go && op == OP_POP;
  assign do_write = go && op == OP_WRITE;
  assign do_xchg  = go && op == OP_XCHG;

  // ---- write port A: push target, write target, or ST0 side of exchange
  always_comb begin
    wa_en   = do_push | do_write | do_xchg;
    wa_addr = phys;
    wa_data = wdata_i;
    if (do_push) wa_addr = top_dec;
    if (do_xchg) begin
      wa_addr = top;
      wa_data = rd_phys;
    end
  end

  assign ra_addr = (op == OP_POP || op == OP_XCHG) ? top : phys;
  assign rdata_o = rd_top;
  assign top_o   = top;

  fpst_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .dec_i    (do_push),
    .inc_i    (do_pop),
    .idx_i    (idx_i),
    .top_o    (top),
    .top_dec_o(top_dec),
    .phys_o   (phys)
  );

  fpst_tags #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .set_en_i (do_push | do_write),
    .set_idx_i(do_push ? top_dec : phys),
    .clr_en_i (do_pop),
    .clr_idx_i(top),
    .valid_o  (valid)
  );

  fpst_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_rf (
    .clk      (clk),
    .wa_en_i  (wa_en),
    .wa_addr_i(wa_addr),
    .wa_data_i(wa_data),
    .wb_en_i  (do_xchg),
    .wb_addr_i(phys),
    .wb_data_i(rd_top),
    .ra_addr_i(ra_addr),
    .ra_data_o(rd_top),
    .rb_addr_i(phys),
    .rb_data_o(rd_phys)
  );

  // ---- assertions
  p_init_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (top_o == '0) && (valid == '0));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !stk_fault_o && !init_i) |=>
      (top_o == PTR_W'($past(top_o) - PTR_W'(1))) && valid[top_o]);

  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && !stk_fault_o && !init_i) |=>
      (top_o == PTR_W'($past(top_o) + PTR_W'(1))) && !valid[$past(top_o)]);

  p_ovf_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_fault_o && op == OP_PUSH) |-> (c1_o && invalid_o));

  p_unf_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_fault_o && op != OP_PUSH) |-> (!c1_o && invalid_o));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault_o |=> $stable(top_o) && $stable(valid));

  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i > 3'd5) |-> !stk_fault_o);
endmodule

// File: tb/fp_regstack_bench.sv
module fp_regstack_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_i;
  logic [2:0]  op_i;
  logic [2:0]  idx_i;
  logic [79:0] wdata_i;
  logic [79:0] rdata_o;
  logic [2:0]  top_o;
  logic        stk_fault_o, c1_o, invalid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fp_regstack u_fp_regstack (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .op_i(op_i), .idx_i(idx_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .top_o(top_o),
    .stk_fault_o(stk_fault_o), .c1_o(c1_o), .invalid_o(invalid_o)
  );

  // vector: op[43:41] idx[40:38] wval[37:22] chk[21] exp[20:5] flt[4] c1[3] top[2:0]
  localparam int NV = 19;
  localparam logic [43:0] VEC [NV] = '{
    {3'd2,3'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0,3'd0}, // R6 R1 pop on empty
    {3'd3,3'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0,3'd0}, // R6 read empty
    {3'd1,3'd0,16'h1111,1'b0,16'h0000,1'b0,1'b0,3'd0}, // R2 push
    {3'd1,3'd0,16'h2222,1'b0,16'h0000,1'b0,1'b0,3'd7}, // R2 push, wrap
    {3'd3,3'd0,16'h0000,1'b1,16'h2222,1'b0,1'b0,3'd6}, // R2 new ST0
    {3'd3,3'd1,16'h0000,1'b1,16'h1111,1'b0,1'b0,3'd6}, // R3 old ST0 now ST1
    {3'd3,3'd2,16'h0000,1'b0,16'h0000,1'b1,1'b0,3'd6}, // R6 read empty ST2
    {3'd5,3'd1,16'h0000,1'b0,16'h0000,1'b0,1'b0,3'd6}, // R9 exchange
    {3'd3,3'd0,16'h0000,1'b1,16'h1111,1'b0,1'b0,3'd6}, // R9 swapped
    {3'd5,3'd3,16'h0000,1'b0,16'h0000,1'b1,1'b0,3'd6}, // R9 exchange with empty
    {3'd4,3'd2,16'h3333,1'b0,16'h0000,1'b0,1'b0,3'd6}, // R8 write empty slot
    {3'd3,3'd2,16'h0000,1'b1,16'h3333,1'b0,1'b0,3'd6}, // R8 readback, R3 wrap
    {3'd2,3'd0,16'h0000,1'b1,16'h1111,1'b0,1'b0,3'd6}, // R4 pop
    {3'd3,3'd0,16'h0000,1'b1,16'h2222,1'b0,1'b0,3'd7}, // R4 top advanced
    {3'd3,3'd1,16'h0000,1'b1,16'h3333,1'b0,1'b0,3'd7}, // R3 physical 0
    {3'd2,3'd0,16'h0000,1'b1,16'h2222,1'b0,1'b0,3'd7}, // R4 pop wraps to 0
    {3'd2,3'd0,16'h0000,1'b1,16'h3333,1'b0,1'b0,3'd0}, // R4 pop
    {3'd2,3'd0,16'h0000,1'b0,16'h0000,1'b1,1'b0,3'd1}, // R6 pop emptied stack
    {3'd6,3'd0,16'h0000,1'b0,16'h0000,1'b0,1'b0,3'd1}  // R10 unused code
  };
  localparam string VREQ [NV] = '{
    "R6","R6","R2","R2","R2","R3","R6","R9","R9","R9",
    "R8","R8","R4","R4","R3","R4","R4","R6","R10"
  };

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] w);
    @(negedge clk);
    op_i = op; idx_i = idx; wdata_i = w;
    #5;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    rst_n = 1'b0; init_i = 1'b0; op_i = 3'd0; idx_i = 3'd0; wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #5;
    check("R1 reset top", 80'(top_o), 80'd0);
    check("R1 reset quiet", 80'(stk_fault_o), 80'd0);

    for (int k = 0; k < NV; k++) begin
      logic [43:0] v;
      v = VEC[k];
      drive(v[43:41], v[40:38], {5{v[37:22]}});
      check(VREQ[k], 80'(top_o), 80'(v[2:0]));
      check(VREQ[k], 80'(stk_fault_o), 80'(v[4]));
      check(VREQ[k], 80'(invalid_o), 80'(v[4]));
      check(VREQ[k], 80'(c1_o), 80'(v[3]));
      if (v[21]) check(VREQ[k], rdata_o, {5{v[20:5]}});
    end

    // R5: fill all eight slots, then one more push overflows
    for (int k = 0; k < 8; k++) begin
      drive(3'd1, 3'd0, {5{16'h4000 + 16'(k)}});
      check("R2 fill", 80'(stk_fault_o), 80'd0);
    end
    drive(3'd1, 3'd0, {5{16'hDEAD}});
    check("R5 overflow fault", 80'(stk_fault_o), 80'd1);
    check("R5 overflow invalid", 80'(invalid_o), 80'd1);
    check("R5 overflow c1", 80'(c1_o), 80'd1);
    // R7: state after the rejected push
    drive(3'd3, 3'd0, '0);
    check("R7 top held", 80'(top_o), 80'd1);
    check("R7 ST0 held", rdata_o, {5{16'h4007}});
    drive(3'd3, 3'd7, '0);
    check("R7 ST7 held", rdata_o, {5{16'h4000}});
    // R8: overwrite a valid slot, no fault
    drive(3'd4, 3'd3, {5{16'h5555}});
    check("R8 write valid no fault", 80'(stk_fault_o), 80'd0);
    drive(3'd3, 3'd3, '0);
    check("R8 overwrite", rdata_o, {5{16'h5555}});
    // R9: exchange on a full stack with wrapped index
    drive(3'd5, 3'd7, '0);
    check("R9 xchg ok", 80'(stk_fault_o), 80'd0);
    drive(3'd3, 3'd0, '0);
    check("R9 new ST0", rdata_o, {5{16'h4000}});
    drive(3'd3, 3'd7, '0);
    check("R9 new ST7", rdata_o, {5{16'h4007}});

    // R1: initialise overrides a concurrent push
    @(negedge clk);
    init_i = 1'b1; op_i = 3'd1; wdata_i = '0;
    #5;
    check("R1 init quiet", 80'(stk_fault_o), 80'd0);
    @(negedge clk) init_i = 1'b0;
    op_i = 3'd2; #5;
    check("R1 init top", 80'(top_o), 80'd0);
    check("R1 init empties", 80'(stk_fault_o), 80'd1);
    check("R6 pop c1", 80'(c1_o), 80'd0);

    @(negedge clk) op_i = 3'd0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule